// File: doc/BRIEF.md
# Unaligned Write Splitter with Byte Masking

This block converts a single-beat write request, given as a byte address, one 32-byte data word and a per-byte strobe vector, into aligned write commands for a memory port. That port moves exactly one 32-byte unit per command. The low five address bits are the byte offset inside a unit. A request with a zero offset maps onto one unit. A request with a nonzero offset straddles two adjacent units. The block shifts the data and the strobes up by the offset, sends the lower part to the unit that holds the address, and sends the spill-over part to the next unit up.

With the protection mode off, each command carries a per-byte write enable, so the untouched bytes of a unit are simply not written. With the protection mode on, the memory cannot take partial writes. Each unit whose enables are not all set is then first read through a separate read port, merged with the new bytes, and written back whole. The mode is sampled together with each request. The request input stays stalled until every command for it has been accepted. A response handshake then closes the request.

Top module: `wr_split_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `rd_valid` and `rsp_valid` are 0.
- R2: A request whose `req_addr[4:0]` is zero produces exactly one command. Its address equals `req_addr`, its data equals `req_data`, and in mask mode `cmd_mask` equals `req_strb`. Bit i of a mask or strobe governs byte i, occupying data bits [8i+7:8i], and 1 means the byte is written.
- R3: A request with offset o = `req_addr[4:0]` nonzero produces a first command at `req_addr` with bits [4:0] cleared. Byte j of that command (j ≥ o) is request byte j−o. Byte j of the second command, at the first address plus 32 (j < o), is request byte 32−o+j. All other bytes carry zero data and a zero strobe.
- R4: When no strobe bit lands in the second unit, the second command is not issued.
- R5: Requests with partial or all-zero strobes are accepted. Each unit used still takes one full 32-byte command, with the mask reflecting the strobes.
- R6: With `ecc_mode` set when the request is accepted, every command carries an all-ones `cmd_mask`.
- R7: With `ecc_mode` set, every unit whose strobes are not all 1 is read at its unit address before it is written. The written word takes the read byte where the strobe is 0 and the new byte where it is 1. Read data is taken on the cycle `rd_rvalid` is 1.
- R8: With `ecc_mode` set, a unit whose strobes are all 1 is written without a read.
- R9: With `ecc_mode` set and a nonzero offset, each of the two units runs its own read-merge-write sequence. The lower unit goes first, and the upper unit is skipped under the rule of R4.
- R10: `req_ready` stays 0 from request acceptance until the response handshake. `rsp_valid` rises only after the last command has been accepted and is held until `rsp_ready`.
- R11: While `cmd_valid` or `rd_valid` is 1 and not accepted, it stays 1, and its address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_mode | input | 1 | Protection mode, sampled with each accepted request |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | 8*UNIT_BYTES | Request data, byte i in bits [8i+7:8i] |
| req_strb | input | UNIT_BYTES | Request byte strobes |
| rsp_valid | output | 1 | Write response valid |
| rsp_ready | input | 1 | Response accepted |
| cmd_valid | output | 1 | Memory write command valid |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_addr | output | ADDR_W | Unit-aligned write address |
| cmd_data | output | 8*UNIT_BYTES | Write data for the unit |
| cmd_mask | output | UNIT_BYTES | Per-byte write enable, 1 = write |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Unit-aligned read address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 8*UNIT_BYTES | Read data for the unit |

## Verification
Two functions can meet on one clock edge. The first is the acceptance of the lower unit's write command. The second is the start of the upper unit's sequence, which must choose at that same edge between a read, in protection mode with partial strobes, and a direct write. The bench provokes this by sweeping every offset under several strobe patterns in both modes, while `cmd_ready` drops on a fixed rhythm. Each request is judged by the exact ordered lists of read and write addresses, and by the merged or masked data the bench derives by byte arithmetic from a known memory content function.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR      = 3'd3,
    ST_RSP     = 3'd4
  } wsplit_state_e;
endpackage

// File: rtl/wsplit_rotate.sv
// Shifts a unit of data and strobes up by a byte offset across two units.
module wsplit_rotate #(
  parameter int UNIT_BYTES = 32
) (
  input  logic [$clog2(UNIT_BYTES)-1:0] ofs,
  input  logic [8*UNIT_BYTES-1:0]       data,
  input  logic [UNIT_BYTES-1:0]         strb,
  output logic [8*UNIT_BYTES-1:0]       lo_data,
  output logic [8*UNIT_BYTES-1:0]       hi_data,
  output logic [UNIT_BYTES-1:0]         lo_strb,
  output logic [UNIT_BYTES-1:0]         hi_strb
);
  localparam int DATA_W = 8 * UNIT_BYTES;
  localparam int OFS_W  = $clog2(UNIT_BYTES);

  logic [2*DATA_W-1:0]     wide_d;
  logic [2*UNIT_BYTES-1:0] wide_s;
  logic [OFS_W+2:0]        bit_sh;

  always_comb begin
    bit_sh  = {ofs, 3'b000};
    wide_d  = {{DATA_W{1'b0}}, data} << bit_sh;
    wide_s  = {{UNIT_BYTES{1'b0}}, strb} << ofs;
    lo_data = wide_d[DATA_W-1:0];
    hi_data = wide_d[2*DATA_W-1:DATA_W];
    lo_strb = wide_s[UNIT_BYTES-1:0];
    hi_strb = wide_s[2*UNIT_BYTES-1:UNIT_BYTES];
  end
endmodule

// File: rtl/wsplit_merge.sv
// Byte-wise merge of fresh bytes over an old unit.
module wsplit_merge #(
  parameter int UNIT_BYTES = 32
) (
  input  logic [8*UNIT_BYTES-1:0] old_data,
  input  logic [8*UNIT_BYTES-1:0] new_data,
  input  logic [UNIT_BYTES-1:0]   sel_new,
  output logic [8*UNIT_BYTES-1:0] merged
);
  for (genvar b = 0; b < UNIT_BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = sel_new[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
  end
endmodule

// File: rtl/wr_split_top.sv
module wr_split_top
  import wsplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int UNIT_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ecc_mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [8*UNIT_BYTES-1:0] req_data,
  input  logic [UNIT_BYTES-1:0]   req_strb,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [ADDR_W-1:0]       cmd_addr,
  output logic [8*UNIT_BYTES-1:0] cmd_data,
  output logic [UNIT_BYTES-1:0]   cmd_mask,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic                    rd_rvalid,
  input  logic [8*UNIT_BYTES-1:0] rd_rdata
);
  localparam int DATA_W = 8 * UNIT_BYTES;
  localparam int OFS_W  = $clog2(UNIT_BYTES);
  localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(UNIT_BYTES);

  wsplit_state_e           state_q;
  logic                    sel_q;      // 0 = lower unit, 1 = upper unit
  logic                    ecc_q;
  logic                    need_hi_q;
  logic [ADDR_W-1:0]       base_q;
  logic [ADDR_W-1:0]       cur_addr_q;
  logic [DATA_W-1:0]       data0_q, data1_q;
  logic [UNIT_BYTES-1:0]   strb0_q, strb1_q;

  logic [DATA_W-1:0]       rot_lo_d, rot_hi_d;
  logic [UNIT_BYTES-1:0]   rot_lo_s, rot_hi_s;
  logic [DATA_W-1:0]       cur_data, merged;
  logic [UNIT_BYTES-1:0]   cur_strb;
  logic                    req_fire;

  wsplit_rotate #(.UNIT_BYTES(UNIT_BYTES)) i_rotate (
    .ofs     (req_addr[OFS_W-1:0]),
    .data    (req_data),
    .strb    (req_strb),
    .lo_data (rot_lo_d),
    .hi_data (rot_hi_d),
    .lo_strb (rot_lo_s),
    .hi_strb (rot_hi_s)
  );

  assign cur_data = sel_q ? data1_q : data0_q;
  assign cur_strb = sel_q ? strb1_q : strb0_q;

  wsplit_merge #(.UNIT_BYTES(UNIT_BYTES)) i_merge (
    .old_data (rd_rdata),
    .new_data (cur_data),
    .sel_new  (cur_strb),
    .merged   (merged)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign cmd_valid = (state_q == ST_WR);
  assign rd_valid  = (state_q == ST_RD_REQ);
  assign rsp_valid = (state_q == ST_RSP);
  assign cmd_addr  = cur_addr_q;
  assign rd_addr   = cur_addr_q;
  assign cmd_data  = cur_data;
  assign cmd_mask  = ecc_q ? {UNIT_BYTES{1'b1}} : cur_strb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sel_q      <= 1'b0;
      ecc_q      <= 1'b0;
      need_hi_q  <= 1'b0;
      base_q     <= '0;
      cur_addr_q <= '0;
      data0_q    <= '0;
      data1_q    <= '0;
      strb0_q    <= '0;
      strb1_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            base_q     <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            cur_addr_q <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            data0_q    <= rot_lo_d;
            data1_q    <= rot_hi_d;
            strb0_q    <= rot_lo_s;
            strb1_q    <= rot_hi_s;
            ecc_q      <= ecc_mode;
            need_hi_q  <= |rot_hi_s;
            sel_q      <= 1'b0;
            state_q    <= (ecc_mode && !(&rot_lo_s)) ? ST_RD_REQ : ST_WR;
          end
        end
        ST_RD_REQ: begin
          if (rd_ready) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rd_rvalid) begin
            if (sel_q) data1_q <= merged;
            else       data0_q <= merged;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (cmd_ready) begin
            if (!sel_q && need_hi_q) begin
              sel_q      <= 1'b1;
              cur_addr_q <= base_q + UNIT_STEP;
              state_q    <= (ecc_q && !(&strb1_q)) ? ST_RD_REQ : ST_WR;
            end else begin
              state_q <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Every emitted command sits on a unit boundary
  assert_cmd_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr[OFS_W-1:0] == '0));

  // Upper-unit command goes to the unit just above the lower one
  assert_upper_unit_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sel_q) |-> (cmd_addr == base_q + UNIT_STEP));

  // Protection mode never uses a partial mask
  assert_ecc_mask_full_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ecc_q) |-> (&cmd_mask));

  // Reads only occur in protection mode
  assert_read_only_ecc_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ecc_q);

  // Input stalls while any downstream activity is pending
  assert_input_stalled_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid || rd_valid || rsp_valid) |-> !req_ready);

  // Response follows the final command handshake
  assert_rsp_after_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(cmd_valid && cmd_ready));

  // Response is held until taken
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  // Back-pressured command keeps its payload
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                   && $stable(cmd_data) && $stable(cmd_mask)));

  // Back-pressured read keeps its address
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

// File: tb/test_wr_split_top.sv
module test_wr_split_top;
  localparam int AW = 32;
  localparam int UB = 32;
  localparam int DW = 8 * UB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          ecc_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [UB-1:0] req_strb = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic [UB-1:0] cmd_mask;
  logic          rd_valid;
  logic          rd_ready = 1'b1;
  logic [AW-1:0] rd_addr;
  logic          rd_rvalid = 1'b0;
  logic [DW-1:0] rd_rdata = '0;

  wr_split_top #(.ADDR_W(AW), .UNIT_BYTES(UB)) i_wr_split_top (
    .clk, .rst, .ecc_mode, .req_valid, .req_ready, .req_addr, .req_data, .req_strb,
    .rsp_valid, .rsp_ready, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_data, .cmd_mask,
    .rd_valid, .rd_ready, .rd_addr, .rd_rvalid, .rd_rdata
  );

  int n_checks = 0;
  int n_fail   = 0;
  int mon_checks = 0;
  int mon_fail   = 0;

  // Known memory content: byte i of unit at address a
  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    for (int i = 0; i < UB; i++) r[8*i +: 8] = 8'(a[12:5] * 13 + i * 7 + 8'h5A);
    return r;
  endfunction

  // Monitor state, owned by the negedge process
  logic [AW-1:0] cap_addr [8];
  logic [DW-1:0] cap_data [8];
  logic [UB-1:0] cap_mask [8];
  logic [AW-1:0] rdc_addr [8];
  int tot_cmd = 0, tot_rd = 0, tot_rsp = 0, cmd_at_rsp = 0, cyc = 0;
  bit pend = 1'b0, rsp_seen = 1'b0;
  logic [AW-1:0] pend_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ((cmd_valid || rd_valid || rsp_valid) && req_ready) begin
        mon_checks++; mon_fail++;
        $display("FAIL R10 req_ready act=1 exp=0 while busy at cycle %0d", cyc);
      end
      cmd_ready = (cyc % 3) != 0;
      if (cmd_valid && cmd_ready) begin
        cap_addr[tot_cmd % 8] = cmd_addr;
        cap_data[tot_cmd % 8] = cmd_data;
        cap_mask[tot_cmd % 8] = cmd_mask;
        tot_cmd++;
      end
      rd_rvalid = pend;
      if (pend) rd_rdata = memf(pend_addr);
      pend = 1'b0;
      if (rd_valid && rd_ready) begin
        rdc_addr[tot_rd % 8] = rd_addr;
        tot_rd++;
        pend = 1'b1;
        pend_addr = rd_addr;
      end
      if (rsp_valid && !rsp_seen) cmd_at_rsp = tot_cmd;
      rsp_ready = rsp_seen;
      if (rsp_valid && rsp_ready) tot_rsp++;
      rsp_seen = rsp_valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] addr, input logic [DW-1:0] data,
                         input logic [UB-1:0] strb, input bit ecc);
    int ofs, s_cmd, s_rd, s_rsp, exp_ncmd, exp_nrd, src;
    logic [DW-1:0] ed [2];
    logic [UB-1:0] es [2];
    logic [AW-1:0] ua [2];
    logic [AW-1:0] exp_rd [2];
    logic [DW-1:0] exp_d [2];
    logic [UB-1:0] exp_m [2];
    string tag;
    ofs = int'(addr[4:0]);
    ua[0] = {addr[AW-1:5], 5'b0};
    ua[1] = ua[0] + 32'd32;
    ed[0] = '0; ed[1] = '0; es[0] = '0; es[1] = '0;
    for (int j = 0; j < UB; j++) begin
      if (j >= ofs) begin
        src = j - ofs;
        ed[0][8*j +: 8] = data[8*src +: 8];
        es[0][j] = strb[src];
      end
      if (j < ofs) begin
        src = UB - ofs + j;
        ed[1][8*j +: 8] = data[8*src +: 8];
        es[1][j] = strb[src];
      end
    end
    exp_ncmd = (|es[1]) ? 2 : 1;
    exp_nrd = 0;
    for (int u = 0; u < exp_ncmd; u++) begin
      if (!ecc) begin
        exp_d[u] = ed[u]; exp_m[u] = es[u];
      end else begin
        exp_m[u] = '1;
        if (&es[u]) exp_d[u] = ed[u];
        else begin
          exp_rd[exp_nrd] = ua[u];
          exp_nrd++;
          exp_d[u] = ed[u];
          for (int b = 0; b < UB; b++)
            if (!es[u][b]) exp_d[u][8*b +: 8] = memf(ua[u])[8*b +: 8];
        end
      end
    end
    if (ecc) tag = (ofs != 0) ? "R9" : ((&strb) ? "R8" : "R7");
    else     tag = (ofs != 0) ? "R3" : ((strb == '0) ? "R5" : "R2");

    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready idle", DW'(req_ready), DW'(1));
    s_cmd = tot_cmd; s_rd = tot_rd; s_rsp = tot_rsp;
    req_valid = 1'b1; req_addr = addr; req_data = data; req_strb = strb; ecc_mode = ecc;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_data = '0; req_strb = '0; ecc_mode = 1'b0;
    while (tot_rsp == s_rsp) @(negedge clk);

    chk(tot_cmd - s_cmd == exp_ncmd, (exp_ncmd == 1 && ofs != 0) ? "R4" : tag,
        "command count", DW'(tot_cmd - s_cmd), DW'(exp_ncmd));
    chk(cmd_at_rsp - s_cmd == exp_ncmd, "R10", "commands before response",
        DW'(cmd_at_rsp - s_cmd), DW'(exp_ncmd));
    if (tot_cmd - s_cmd == exp_ncmd) begin
      for (int u = 0; u < exp_ncmd; u++) begin
        chk(cap_addr[(s_cmd + u) % 8] == ua[u], tag, "cmd_addr",
            DW'(cap_addr[(s_cmd + u) % 8]), DW'(ua[u]));
        chk(cap_data[(s_cmd + u) % 8] == exp_d[u], tag, "cmd_data",
            cap_data[(s_cmd + u) % 8], exp_d[u]);
        chk(cap_mask[(s_cmd + u) % 8] == exp_m[u], ecc ? "R6" : tag, "cmd_mask",
            DW'(cap_mask[(s_cmd + u) % 8]), DW'(exp_m[u]));
      end
    end
    if (ecc || tot_rd != s_rd)
      chk(tot_rd - s_rd == exp_nrd, ecc ? tag : "R7", "read count",
          DW'(tot_rd - s_rd), DW'(exp_nrd));
    if (tot_rd - s_rd == exp_nrd)
      for (int r = 0; r < exp_nrd; r++)
        chk(rdc_addr[(s_rd + r) % 8] == exp_rd[r], tag, "rd_addr",
            DW'(rdc_addr[(s_rd + r) % 8]), DW'(exp_rd[r]));
  endtask

  task automatic finish_run();
    n_checks += mon_checks;
    n_fail   += mon_fail;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic [UB-1:0] pat;
    logic [DW-1:0] dat;
    int k;
    k = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", DW'(req_ready), DW'(1));
    chk({cmd_valid, rd_valid, rsp_valid} == 3'b000, "R1", "valids in reset",
        DW'({cmd_valid, rd_valid, rsp_valid}), DW'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", DW'(req_ready), DW'(1));
    chk({cmd_valid, rd_valid, rsp_valid} == 3'b000, "R1", "valids after reset",
        DW'({cmd_valid, rd_valid, rsp_valid}), DW'(0));
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 7; p++) begin
        case (p)
          0: pat = '1;
          1: pat = '0;
          2: pat = 32'h0000_0001;
          3: pat = 32'h8000_0000;
          4: pat = 32'h5555_5555;
          5: pat = 32'h0000_FFFF;
          default: pat = 32'hF0F0_3C01;
        endcase
        for (int o = 0; o < UB; o++) begin
          for (int i = 0; i < UB; i++) dat[8*i +: 8] = 8'(k * 29 + i * 11 + 3);
          run_req(32'h1000_0000 + AW'(k << 5) + AW'(o), dat, pat, e[0]);
          k++;
        end
      end
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule